// File: doc/BRIEF.md
# USB Control Transfer Stage Sequencer

This block follows a USB device control transfer on a single endpoint. A lower transaction layer reports each completed transaction as a one-cycle event tagged setup, IN or OUT, together with the byte count that moved. A setup event starts a new transfer. It takes the request's direction bit and its 16-bit length field, which are presented with the event. From them the sequencer picks one of three legal shapes: a read, which is data IN followed by status OUT; a write, which is data OUT followed by status IN; or a no-data transfer, which goes straight to status IN.

While the transfer runs, the block tells the transaction layer which data PID toggle to use. When the status stage is IN, it also asks for a zero-length packet. When a status transaction finishes, the block returns to idle and pulses a completion output.

Any transaction in the wrong direction moves the endpoint to a halted stage. A firmware stall request does the same. The endpoint then answers with a stall until the next setup. If the endpoint is configured for double buffering, it is treated as misconfigured and held halted.

Top module: `ctrl_xfer_seq`

## Requirements
- R1: A setup event (evt_kind 0) clears any transfer in progress and sets data1_o. If the length is zero, the stage becomes status IN (code 3). Otherwise, direction bit 1 selects data IN (code 1) and direction bit 0 selects data OUT (code 2). The other stage codes are idle 0, status OUT 4 and halted 5.
- R2: In a data stage, each transaction in the matching direction (IN is kind 1, OUT is kind 2) that does not end the stage inverts data1_o.
- R3: The data stage ends on the transaction that brings the accumulated byte count to at least the requested length, or on one that carries fewer than MAX_PKT bytes. Data IN then moves to status OUT and data OUT moves to status IN, and data1_o is set.
- R4: In the status IN stage, zlp_o is high and data1_o is high. In every other stage, zlp_o is low.
- R5: A status transaction in the expected direction returns the stage to idle. It raises done_o for exactly one cycle.
- R6: A transaction in the wrong direction during a data or status stage moves the stage to halted and raises stall_o. IN and OUT events leave the halted stage unchanged, and only a setup leaves it.
- R7: fw_stall moves any stage to halted. If a setup event arrives in the same cycle, the setup takes priority.
- R8: While pingpong_en is high, the stage is forced to halted on every cycle and setup events are ignored.
- R9: An IN or OUT event while idle moves the stage to halted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pingpong_en | input | 1 | Endpoint configured as double-buffered (illegal for control) |
| fw_stall | input | 1 | Firmware request to abort with a stall |
| evt_valid | input | 1 | A transaction completed this cycle |
| evt_kind | input | 2 | 0 setup, 1 IN, 2 OUT |
| evt_bytes | input | $clog2(MAX_PKT+1) | Bytes moved by the transaction |
| setup_dir | input | 1 | Request direction bit, 1 = device to host |
| setup_length | input | LEN_W | Requested data stage length |
| stage_o | output | 3 | Current stage code |
| stall_o | output | 1 | Answer transactions with a stall |
| data1_o | output | 1 | PID toggle for the next data packet (1 = DATA1) |
| zlp_o | output | 1 | Next IN packet must have zero length |
| done_o | output | 1 | One-cycle pulse when a transfer completes |

## Verification
The bound checker watches several properties on every cycle. It checks the stage chosen by a setup, the toggle inversion on data packets that do not end the stage, and the DATA1 toggle during status IN. It also checks that done_o is a single-cycle pulse seen only in idle, that the halted stage persists until a setup, and that firmware stalls, ping-pong configuration and direction errors lead to a stall.

Some behaviour can only be shown by the directed scenarios. These cover the exact point where the data stage ends: an exact multiple of the packet size, a short packet, and a length reached mid-packet. They also cover a new setup overriding a transfer in flight, the recovery from halted, and the complete sequence of toggles across each of the three transfer shapes.

// File: rtl/ctrl_seq_pkg.sv
package ctrl_seq_pkg;

  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_DIN  = 3'd1,
    ST_DOUT = 3'd2,
    ST_SIN  = 3'd3,
    ST_SOUT = 3'd4,
    ST_HALT = 3'd5
  } stage_e;

  typedef enum logic [1:0] {
    EV_SETUP = 2'd0,
    EV_IN    = 2'd1,
    EV_OUT   = 2'd2,
    EV_RSVD  = 2'd3
  } evt_e;

endpackage

// File: rtl/cxs_setup_dec.sv
// Picks the first stage of a transfer from the setup request fields.
module cxs_setup_dec #(
  parameter int LEN_W = 16
) (
  input  logic             dir_in,
  input  logic [LEN_W-1:0] req_len,
  output ctrl_seq_pkg::stage_e first_stage
);
  import ctrl_seq_pkg::*;

  always_comb begin
    if (req_len == '0)
      first_stage = ST_SIN;
    else if (dir_in)
      first_stage = ST_DIN;
    else
      first_stage = ST_DOUT;
  end
endmodule

// File: rtl/cxs_byte_acc.sv
// Accumulates data-stage bytes and flags the transaction that ends the stage.
module cxs_byte_acc #(
  parameter int LEN_W   = 16,
  parameter int MAX_PKT = 64,
  parameter int PKT_W   = $clog2(MAX_PKT + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clear,
  input  logic             add,
  input  logic [LEN_W-1:0] req_len,
  input  logic [PKT_W-1:0] pkt_bytes,
  output logic             last
);
  localparam int CNT_W = LEN_W + 1;

  logic [CNT_W-1:0] cnt_q;
  logic [LEN_W-1:0] len_q;
  logic [CNT_W-1:0] sum;

  assign sum  = cnt_q + CNT_W'(pkt_bytes);
  assign last = (sum >= {1'b0, len_q}) || (pkt_bytes < PKT_W'(MAX_PKT));

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
      len_q <= '0;
    end else if (clear) begin
      cnt_q <= '0;
      len_q <= req_len;
    end else if (add) begin
      cnt_q <= sum;
    end
  end
endmodule

// File: rtl/cxs_toggle.sv
// Data PID toggle: forced to DATA1 on load, inverted on flip.
module cxs_toggle (
  input  logic clk,
  input  logic rst,
  input  logic load1,
  input  logic flip,
  output logic tog
);
  always_ff @(posedge clk) begin
    if (rst)        tog <= 1'b0;
    else if (load1) tog <= 1'b1;
    else if (flip)  tog <= ~tog;
  end
endmodule

// File: rtl/ctrl_xfer_seq.sv
// Control transfer stage sequencer for one endpoint.
module ctrl_xfer_seq #(
  parameter int LEN_W   = 16,
  parameter int MAX_PKT = 64,
  parameter int PKT_W   = $clog2(MAX_PKT + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             pingpong_en,
  input  logic             fw_stall,
  input  logic             evt_valid,
  input  logic [1:0]       evt_kind,
  input  logic [PKT_W-1:0] evt_bytes,
  input  logic             setup_dir,
  input  logic [LEN_W-1:0] setup_length,
  output logic [2:0]       stage_o,
  output logic             stall_o,
  output logic             data1_o,
  output logic             zlp_o,
  output logic             done_o
);
  import ctrl_seq_pkg::*;

  stage_e stage_q, stage_n, first_stage;
  logic   done_q, done_n;
  logic   tog_load1, tog_flip, acc_clear, acc_add, acc_last;
  logic   is_setup, is_in, is_out;

  assign is_setup = evt_valid && (evt_kind == EV_SETUP);
  assign is_in    = evt_valid && (evt_kind == EV_IN);
  assign is_out   = evt_valid && (evt_kind == EV_OUT);

  cxs_setup_dec #(.LEN_W(LEN_W)) u_dec (
    .dir_in      (setup_dir),
    .req_len     (setup_length),
    .first_stage (first_stage)
  );

  cxs_byte_acc #(.LEN_W(LEN_W), .MAX_PKT(MAX_PKT), .PKT_W(PKT_W)) u_acc (
    .clk       (clk),
    .rst       (rst),
    .clear     (acc_clear),
    .add       (acc_add),
    .req_len   (setup_length),
    .pkt_bytes (evt_bytes),
    .last      (acc_last)
  );

  cxs_toggle u_tog (
    .clk   (clk),
    .rst   (rst),
    .load1 (tog_load1),
    .flip  (tog_flip),
    .tog   (data1_o)
  );

  always_comb begin
    stage_n   = stage_q;
    done_n    = 1'b0;
    tog_load1 = 1'b0;
    tog_flip  = 1'b0;
    acc_clear = 1'b0;
    acc_add   = 1'b0;
    if (pingpong_en) begin
      stage_n = ST_HALT;
    end else if (is_setup) begin
      stage_n   = first_stage;
      acc_clear = 1'b1;
      tog_load1 = 1'b1;
    end else if (fw_stall) begin
      stage_n = ST_HALT;
    end else if (is_in || is_out) begin
      unique case (stage_q)
        ST_IDLE: stage_n = ST_HALT;
        ST_DIN: begin
          if (is_in) begin
            acc_add = 1'b1;
            if (acc_last) begin
              stage_n   = ST_SOUT;
              tog_load1 = 1'b1;
            end else begin
              tog_flip = 1'b1;
            end
          end else begin
            stage_n = ST_HALT;
          end
        end
        ST_DOUT: begin
          if (is_out) begin
            acc_add = 1'b1;
            if (acc_last) begin
              stage_n   = ST_SIN;
              tog_load1 = 1'b1;
            end else begin
              tog_flip = 1'b1;
            end
          end else begin
            stage_n = ST_HALT;
          end
        end
        ST_SIN: begin
          if (is_in) begin
            stage_n = ST_IDLE;
            done_n  = 1'b1;
          end else begin
            stage_n = ST_HALT;
          end
        end
        ST_SOUT: begin
          if (is_out) begin
            stage_n = ST_IDLE;
            done_n  = 1'b1;
          end else begin
            stage_n = ST_HALT;
          end
        end
        default: stage_n = ST_HALT;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      stage_q <= ST_IDLE;
      done_q  <= 1'b0;
    end else begin
      stage_q <= stage_n;
      done_q  <= done_n;
    end
  end

  assign stage_o = stage_q;
  assign stall_o = (stage_q == ST_HALT);
  assign zlp_o   = (stage_q == ST_SIN);
  assign done_o  = done_q;
endmodule

// File: rtl/cxs_checker.sv
module cxs_checker #(
  parameter int LEN_W   = 16,
  parameter int PKT_W   = 7
) (
  input logic             clk,
  input logic             rst,
  input logic             pingpong_en,
  input logic             fw_stall,
  input logic             evt_valid,
  input logic [1:0]       evt_kind,
  input logic [PKT_W-1:0] evt_bytes,
  input logic             setup_dir,
  input logic [LEN_W-1:0] setup_length,
  input logic [2:0]       stage_o,
  input logic             stall_o,
  input logic             data1_o,
  input logic             zlp_o,
  input logic             done_o
);
  logic setup_ev;
  assign setup_ev = evt_valid && (evt_kind == 2'd0);

  p_setup_read_r1: assert property (@(posedge clk) disable iff (rst)
    (setup_ev && !pingpong_en && setup_dir && setup_length != '0) |=> (stage_o == 3'd1 && data1_o));

  p_setup_nodata_r1: assert property (@(posedge clk) disable iff (rst)
    (setup_ev && !pingpong_en && setup_length == '0) |=> (stage_o == 3'd3 && data1_o));

  p_data_flip_r2: assert property (@(posedge clk) disable iff (rst)
    (stage_o == 3'd1 && evt_valid && evt_kind == 2'd1 && !fw_stall && !pingpong_en)
      |=> (stage_o == 3'd4) || (data1_o != $past(data1_o)));

  p_status_tog_r4: assert property (@(posedge clk) disable iff (rst)
    (stage_o == 3'd3) |-> data1_o);

  p_done_pulse_r5: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !done_o);

  p_done_idle_r5: assert property (@(posedge clk) disable iff (rst)
    done_o |-> (stage_o == 3'd0));

  p_halt_sticky_r6: assert property (@(posedge clk) disable iff (rst)
    (stage_o == 3'd5 && !setup_ev) |=> stall_o);

  p_mismatch_r6: assert property (@(posedge clk) disable iff (rst)
    (stage_o == 3'd1 && evt_valid && evt_kind == 2'd2) |=> stall_o);

  p_fw_stall_r7: assert property (@(posedge clk) disable iff (rst)
    (fw_stall && !setup_ev) |=> stall_o);

  p_pingpong_r8: assert property (@(posedge clk) disable iff (rst)
    pingpong_en |=> stall_o);

  p_zlp_r4: assert property (@(posedge clk) disable iff (rst)
    zlp_o |-> !stall_o && !done_o);

  logic unused_ok;
  assign unused_ok = ^evt_bytes;
endmodule

bind ctrl_xfer_seq cxs_checker #(.LEN_W(LEN_W), .PKT_W(PKT_W)) u_cxs_checker (
  .clk          (clk),
  .rst          (rst),
  .pingpong_en  (pingpong_en),
  .fw_stall     (fw_stall),
  .evt_valid    (evt_valid),
  .evt_kind     (evt_kind),
  .evt_bytes    (evt_bytes),
  .setup_dir    (setup_dir),
  .setup_length (setup_length),
  .stage_o      (stage_o),
  .stall_o      (stall_o),
  .data1_o      (data1_o),
  .zlp_o        (zlp_o),
  .done_o       (done_o)
);

// File: tb/tb_ctrl_xfer_seq.sv
module tb_ctrl_xfer_seq;
  localparam int LEN_W = 16;
  localparam int MAX_PKT = 64;
  localparam int PKT_W = $clog2(MAX_PKT + 1);

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic pingpong_en = 1'b0;
  logic fw_stall = 1'b0;
  logic evt_valid = 1'b0;
  logic [1:0] evt_kind = 2'd0;
  logic [PKT_W-1:0] evt_bytes = '0;
  logic setup_dir = 1'b0;
  logic [LEN_W-1:0] setup_length = '0;
  logic [2:0] stage_o;
  logic stall_o, data1_o, zlp_o, done_o;

  int errors = 0;
  int checks = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  ctrl_xfer_seq #(.LEN_W(LEN_W), .MAX_PKT(MAX_PKT)) dut (
    .clk(clk), .rst(rst), .pingpong_en(pingpong_en), .fw_stall(fw_stall),
    .evt_valid(evt_valid), .evt_kind(evt_kind), .evt_bytes(evt_bytes),
    .setup_dir(setup_dir), .setup_length(setup_length),
    .stage_o(stage_o), .stall_o(stall_o), .data1_o(data1_o),
    .zlp_o(zlp_o), .done_o(done_o)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Apply one event across a rising edge, return at the following falling edge.
  task automatic send(input logic [1:0] kind, input int bytes, input logic dir, input int len);
    evt_valid    = 1'b1;
    evt_kind     = kind;
    evt_bytes    = PKT_W'(bytes);
    setup_dir    = dir;
    setup_length = LEN_W'(len);
    @(posedge clk);
    #1;
    evt_valid = 1'b0;
    @(negedge clk);
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic t_reset();
    chk("R5 reset stage idle", stage_o, 0);
    chk("R6 reset no stall", stall_o, 0);
    chk("R5 reset done low", done_o, 0);
  endtask

  task automatic t_read();
    send(2'd0, 0, 1'b1, 100);
    chk("R1 read setup stage", stage_o, 1);
    chk("R1 read setup DATA1", data1_o, 1);
    send(2'd1, 64, 1'b0, 0);
    chk("R2 read stays data IN", stage_o, 1);
    chk("R2 read toggle flips", data1_o, 0);
    send(2'd1, 36, 1'b0, 0);
    chk("R3 read to status OUT", stage_o, 4);
    chk("R3 status toggle DATA1", data1_o, 1);
    chk("R4 no zlp in status OUT", zlp_o, 0);
    send(2'd2, 0, 1'b0, 0);
    chk("R5 read idle", stage_o, 0);
    chk("R5 read done pulse", done_o, 1);
    tick();
    chk("R5 done one cycle", done_o, 0);
  endtask

  task automatic t_write_short();
    send(2'd0, 0, 1'b0, 200);
    chk("R1 write setup stage", stage_o, 2);
    send(2'd2, 64, 1'b0, 0);
    chk("R2 write toggle 0", data1_o, 0);
    send(2'd2, 64, 1'b0, 0);
    chk("R2 write toggle 1", data1_o, 1);
    chk("R2 write still data", stage_o, 2);
    send(2'd2, 10, 1'b0, 0);
    chk("R3 short packet ends stage", stage_o, 3);
    chk("R4 status IN zlp", zlp_o, 1);
    chk("R4 status IN DATA1", data1_o, 1);
    send(2'd1, 0, 1'b0, 0);
    chk("R5 write done", done_o, 1);
    chk("R5 write idle", stage_o, 0);
  endtask

  task automatic t_exact();
    send(2'd0, 0, 1'b1, 128);
    send(2'd1, 64, 1'b0, 0);
    chk("R3 exact first full pkt stays", stage_o, 1);
    send(2'd1, 64, 1'b0, 0);
    chk("R3 exact length reached", stage_o, 4);
    chk("R3 exact status DATA1", data1_o, 1);
    send(2'd2, 0, 1'b0, 0);
    chk("R5 exact done", done_o, 1);
  endtask

  task automatic t_nodata();
    send(2'd0, 0, 1'b0, 0);
    chk("R1 nodata to status IN", stage_o, 3);
    chk("R4 nodata zlp", zlp_o, 1);
    send(2'd1, 0, 1'b0, 0);
    chk("R5 nodata done", done_o, 1);
    send(2'd0, 0, 1'b1, 0);
    chk("R1 nodata dir ignored", stage_o, 3);
    send(2'd1, 0, 1'b0, 0);
    chk("R5 nodata idle", stage_o, 0);
  endtask

  task automatic t_mismatch();
    send(2'd0, 0, 1'b1, 100);
    send(2'd2, 0, 1'b0, 0);
    chk("R6 OUT in data IN halts", stage_o, 5);
    chk("R6 stall raised", stall_o, 1);
    send(2'd1, 64, 1'b0, 0);
    chk("R6 halt sticky on IN", stage_o, 5);
    send(2'd2, 0, 1'b0, 0);
    chk("R6 halt sticky on OUT", stage_o, 5);
    tick();
    chk("R6 halt done stays low", done_o, 0);
    send(2'd0, 0, 1'b1, 10);
    chk("R6 setup recovers", stage_o, 1);
    chk("R6 stall cleared", stall_o, 0);
    send(2'd1, 10, 1'b0, 0);
    send(2'd1, 0, 1'b0, 0);
    chk("R6 IN in status OUT halts", stage_o, 5);
  endtask

  task automatic t_idle_evt();
    send(2'd0, 0, 1'b0, 0);
    send(2'd1, 0, 1'b0, 0);
    chk("R9 back to idle", stage_o, 0);
    send(2'd2, 8, 1'b0, 0);
    chk("R9 OUT in idle halts", stage_o, 5);
  endtask

  task automatic t_fw();
    send(2'd0, 0, 1'b0, 50);
    fw_stall = 1'b1;
    @(posedge clk); #1; fw_stall = 1'b0;
    tick();
    chk("R7 fw stall halts", stage_o, 5);
    fw_stall = 1'b1;
    send(2'd0, 0, 1'b0, 50);
    fw_stall = 1'b0;
    chk("R7 setup beats fw stall", stage_o, 2);
  endtask

  task automatic t_override();
    send(2'd0, 0, 1'b1, 300);
    send(2'd1, 64, 1'b0, 0);
    chk("R1 before override toggle 0", data1_o, 0);
    send(2'd0, 0, 1'b0, 10);
    chk("R1 override to data OUT", stage_o, 2);
    chk("R1 override resets toggle", data1_o, 1);
    send(2'd2, 10, 1'b0, 0);
    chk("R3 length reached in short pkt", stage_o, 3);
    send(2'd1, 0, 1'b0, 0);
  endtask

  task automatic t_pingpong();
    pingpong_en = 1'b1;
    tick();
    tick();
    chk("R8 pingpong halts", stall_o, 1);
    send(2'd0, 0, 1'b1, 20);
    chk("R8 setup ignored", stage_o, 5);
    pingpong_en = 1'b0;
    send(2'd0, 0, 1'b1, 20);
    chk("R8 recovers when cleared", stage_o, 1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    tick();
    t_reset();
    t_read();
    t_write_short();
    t_exact();
    t_nodata();
    t_mismatch();
    t_idle_evt();
    t_fw();
    t_override();
    t_pingpong();
    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule